// File: doc/BRIEF.md
# Lockable Indexed Configuration Register Bank

This block holds a small set of 8-bit processor configuration registers that are reached through two I/O ports. Software first writes a register number to the index port (22h), then makes one read or write at the data port (23h). The selected number is forgotten after that one data access, so every data access needs a fresh index write. Besides three control registers, the bank holds a 32-bit protected region address and two read-only identification bytes.

The stored bits drive a set of decoded controls. These are the source that may request entry into system-management mode, a pause (suspend) request, NMI enable while in management mode, a lock on the cache no-write control bit, and a strong-ordering flag for an address presented on a separate input. A sticky lock bit protects the entry-source field, the NMI enable and the region register against writes made outside management mode. Only reset clears the lock. A map-enable bit opens the full index space and makes every access to the index port raise a trap flag.

Top module: `lockcfg_bank`

## Requirements
- R1: After reset, every register reads 00h, the selected index is invalid, and all decoded control outputs are 0.
- R2: Unused bits read 0 whatever is written. The readable widths are: C1h bits [1:0], C2h bits [3:0], C3h bits [6:0].
- R3: C1h[1:0] selects the management entry source. 00 and 10: `mgmt_entry` stays 0. 01: `mgmt_entry` follows the low `mgmt_pin_n` pin, and `mgmt_insn` is ignored. 11: `mgmt_entry` follows `mgmt_insn`, and the pin is ignored.
- R4: C3h[0] is the lock. Writing 1 sets it, writing 0 leaves it set, and only reset clears it.
- R5: While the lock is 1 and `in_mgmt` is 0, writes to C1h[1:0], to C3h[1] and to the region bytes are ignored. Other bits of C3h and all of C2h stay writable. When `in_mgmt` is 1, all of these bits are writable.
- R6: C3h[3] is map-enable. When it is 1, any read or write at the index port raises `io_trap` in that cycle. When it is 0, `io_trap` stays 0. With map-enable 0, only C1h–C3h, CDh–CFh, FEh and FFh are reachable.
- R7: C3h[4], C3h[5] and C3h[6] raise `strong_order` for addresses 40000000h–7FFFFFFFh, 80000000h–BFFFFFFFh and C0000000h–FFFFFFFFh respectively. Addresses below 40000000h never raise it.
- R8: C2h[0] enables the low-active `pause_pin_n` pin as a source of `pause_req`. When `in_mgmt` is 1, the pin also needs C3h[2] set.
- R9: When C2h[1] is 1, a `halt_done` strobe raises `pause_req` in the same cycle.
- R10: `nmi_in_mgmt` equals C3h[1], and `nw_lock` equals C2h[2].
- R11: After any data-port access the index is invalid. A further data read returns FFh, and a further data write has no effect.
- R12: A read of an unimplemented or unreachable index returns FFh, and a write to one has no effect. A read of the index port returns FFh.
- R13: Region bytes 0, 1 and 2 sit at CDh, CEh and CFh, least significant first. The top byte has no index. FEh and FFh return the ID_LO and ID_HI parameters, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port number (22h index, 23h data) |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid during io_rd |
| io_trap | output | 1 | Index-port access trapped |
| in_mgmt | input | 1 | CPU is in management mode |
| mgmt_pin_n | input | 1 | External management request pin, active low |
| mgmt_insn | input | 1 | Management-entry instruction strobe |
| pause_pin_n | input | 1 | External pause request pin, active low |
| halt_done | input | 1 | HALT executed strobe |
| acc_addr | input | ADDR_W | Address whose ordering is queried |
| mgmt_entry | output | 1 | Request to enter management mode |
| pause_req | output | 1 | Pause request |
| nmi_in_mgmt | output | 1 | NMI recognised while in management mode |
| nw_lock | output | 1 | Forbid changes to the cache no-write bit |
| strong_order | output | 1 | Strong read/write ordering for acc_addr |

## Verification
The hardest state to reach is a lock that is set while the region, the entry source and the NMI bit all hold known non-zero values, followed by writes made both outside and inside management mode. The stimulus loads those fields first and only then sets the lock. It then tries to clear each field with `in_mgmt` low and reads every one back, which shows the writes were ignored. It repeats the same writes with `in_mgmt` high, which shows they take effect while the lock bit stays 1.

// File: rtl/lockcfg_pkg.sv
package lockcfg_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned REGION_BYTES = 4;
    localparam int unsigned REGION_VIS   = 3;
    localparam int unsigned REGION_W     = REGION_BYTES * BYTE_W;

    localparam logic [7:0] IDX_MCTL   = 8'hC1;
    localparam logic [7:0] IDX_PCTL   = 8'hC2;
    localparam logic [7:0] IDX_GCTL   = 8'hC3;
    localparam logic [7:0] IDX_RGN0   = 8'hCD;
    localparam logic [7:0] IDX_RGN_HI = 8'hCF;
    localparam logic [7:0] IDX_ID_LO  = 8'hFE;
    localparam logic [7:0] IDX_ID_HI  = 8'hFF;

    typedef enum logic [1:0] {
        MM_OFF_A = 2'b00,
        MM_PIN   = 2'b01,
        MM_OFF_B = 2'b10,
        MM_INSN  = 2'b11
    } mm_src_e;

    typedef struct packed {
        logic wt_region;
        logic nw_lock;
        logic halt_pause;
        logic pause_en;
    } pctl_t;

    typedef struct packed {
        logic order_q3;
        logic order_q2;
        logic order_q1;
        logic map_en;
        logic pause_in_mgmt;
        logic nmi_en;
        logic lock;
    } gctl_t;

    typedef struct packed {
        logic [7:0]          idx;
        logic                idx_vld;
        mm_src_e             mode;
        pctl_t               pctl;
        gctl_t               gctl;
        logic [REGION_W-1:0] region;
    } bank_t;
endpackage

// File: rtl/lockcfg_decode.sv
module lockcfg_decode
    import lockcfg_pkg::*;
#(
    parameter int unsigned NVIS = REGION_VIS
) (
    input  logic [7:0]      idx,
    input  logic            map_en,
    output logic            hit_mctl,
    output logic            hit_pctl,
    output logic            hit_gctl,
    output logic [NVIS-1:0] hit_rgn,
    output logic            hit_id_lo,
    output logic            hit_id_hi
);
    logic            in_window;
    logic            reach;
    logic [NVIS-1:0] raw_rgn;

    always_comb begin
        in_window = (idx >= IDX_MCTL && idx <= IDX_GCTL)
                 || (idx >= IDX_RGN0 && idx <= IDX_RGN_HI)
                 || (idx >= IDX_ID_LO);
        reach     = map_en || in_window;
        hit_mctl  = reach && (idx == IDX_MCTL);
        hit_pctl  = reach && (idx == IDX_PCTL);
        hit_gctl  = reach && (idx == IDX_GCTL);
        hit_id_lo = reach && (idx == IDX_ID_LO);
        hit_id_hi = reach && (idx == IDX_ID_HI);
    end

    for (genvar g = 0; g < NVIS; g++) begin : g_rgn
        assign raw_rgn[g] = (idx == IDX_RGN0 + 8'(g));
        assign hit_rgn[g] = reach && raw_rgn[g];
    end
endmodule

// File: rtl/lockcfg_regs.sv
module lockcfg_regs
    import lockcfg_pkg::*;
#(
    parameter logic [7:0]  IDX_PORT = 8'h22,
    parameter logic [7:0]  DAT_PORT = 8'h23,
    parameter logic [7:0]  ID_LO    = 8'h5A,
    parameter logic [7:0]  ID_HI    = 8'hA6,
    parameter int unsigned NVIS     = REGION_VIS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [7:0]      io_addr,
    input  logic [7:0]      io_wdata,
    input  logic            in_mgmt,
    input  logic            hit_mctl,
    input  logic            hit_pctl,
    input  logic            hit_gctl,
    input  logic [NVIS-1:0] hit_rgn,
    input  logic            hit_id_lo,
    input  logic            hit_id_hi,
    output logic [7:0]      io_rdata,
    output bank_t           state_q
);
    bank_t d_d;
    bank_t q_q;
    logic  idx_acc;
    logic  dat_acc;
    logic  wr_ok;
    logic  rd_ok;
    logic  guard_open;

    always_comb begin
        d_d        = q_q;
        idx_acc    = (io_addr == IDX_PORT);
        dat_acc    = (io_addr == DAT_PORT);
        wr_ok      = io_wr && dat_acc && q_q.idx_vld;
        rd_ok      = io_rd && !io_wr && dat_acc && q_q.idx_vld;
        guard_open = !q_q.gctl.lock || in_mgmt;

        if (io_wr && idx_acc) begin
            d_d.idx     = io_wdata;
            d_d.idx_vld = 1'b1;
        end else if ((io_wr || io_rd) && dat_acc) begin
            d_d.idx_vld = 1'b0;
        end

        if (wr_ok) begin
            if (hit_mctl && guard_open) begin
                d_d.mode = mm_src_e'(io_wdata[1:0]);
            end
            if (hit_pctl) begin
                d_d.pctl = pctl_t'(io_wdata[3:0]);
            end
            if (hit_gctl) begin
                d_d.gctl      = gctl_t'(io_wdata[6:0]);
                d_d.gctl.lock = q_q.gctl.lock | io_wdata[0];
                if (!guard_open) begin
                    d_d.gctl.nmi_en = q_q.gctl.nmi_en;
                end
            end
            for (int b = 0; b < NVIS; b++) begin
                if (hit_rgn[b] && guard_open) begin
                    d_d.region[b*BYTE_W +: BYTE_W] = io_wdata;
                end
            end
        end

        io_rdata = 8'hFF;
        if (rd_ok) begin
            if (hit_mctl)  io_rdata = {6'b0, q_q.mode};
            if (hit_pctl)  io_rdata = {4'b0, q_q.pctl};
            if (hit_gctl)  io_rdata = {1'b0, q_q.gctl};
            if (hit_id_lo) io_rdata = ID_LO;
            if (hit_id_hi) io_rdata = ID_HI;
            for (int b = 0; b < NVIS; b++) begin
                if (hit_rgn[b]) io_rdata = q_q.region[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= d_d;
        end
    end

    assign state_q = q_q;
endmodule

// File: rtl/lockcfg_ctl.sv
module lockcfg_ctl
    import lockcfg_pkg::*;
#(
    parameter logic [7:0] IDX_PORT = 8'h22
) (
    input  mm_src_e    mode,
    input  pctl_t      pctl,
    input  gctl_t      gctl,
    input  logic       in_mgmt,
    input  logic       mgmt_pin_n,
    input  logic       mgmt_insn,
    input  logic       pause_pin_n,
    input  logic       halt_done,
    input  logic [1:0] addr_qtr,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    output logic       mgmt_entry,
    output logic       pause_req,
    output logic       nmi_in_mgmt,
    output logic       nw_lock,
    output logic       strong_order,
    output logic       io_trap
);
    logic pin_pause;

    always_comb begin
        unique case (mode)
            MM_PIN:  mgmt_entry = !mgmt_pin_n;
            MM_INSN: mgmt_entry = mgmt_insn;
            default: mgmt_entry = 1'b0;
        endcase

        pin_pause = pctl.pause_en && !pause_pin_n && (!in_mgmt || gctl.pause_in_mgmt);
        pause_req = pin_pause || (pctl.halt_pause && halt_done);

        unique case (addr_qtr)
            2'b01:   strong_order = gctl.order_q1;
            2'b10:   strong_order = gctl.order_q2;
            2'b11:   strong_order = gctl.order_q3;
            default: strong_order = 1'b0;
        endcase

        nmi_in_mgmt = gctl.nmi_en;
        nw_lock     = pctl.nw_lock;
        io_trap     = gctl.map_en && (io_rd || io_wr) && (io_addr == IDX_PORT);
    end
endmodule

// File: rtl/lockcfg_bank.sv
module lockcfg_bank
    import lockcfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter logic [7:0]  IDX_PORT = 8'h22,
    parameter logic [7:0]  DAT_PORT = 8'h23,
    parameter logic [7:0]  ID_LO    = 8'h5A,
    parameter logic [7:0]  ID_HI    = 8'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_trap,
    input  logic              in_mgmt,
    input  logic              mgmt_pin_n,
    input  logic              mgmt_insn,
    input  logic              pause_pin_n,
    input  logic              halt_done,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              mgmt_entry,
    output logic              pause_req,
    output logic              nmi_in_mgmt,
    output logic              nw_lock,
    output logic              strong_order
);
    localparam int unsigned NVIS = REGION_VIS;

    bank_t               st;
    logic                hit_mctl;
    logic                hit_pctl;
    logic                hit_gctl;
    logic [NVIS-1:0]     hit_rgn;
    logic                hit_id_lo;
    logic                hit_id_hi;
    logic                lock_w;
    logic                nmi_w;
    logic [1:0]          mode_w;
    logic [REGION_W-1:0] region_w;
    logic                idx_vld_w;
    logic [7:0]          idx_w;
    logic                unused_addr_bits;

    assign lock_w           = st.gctl.lock;
    assign nmi_w            = st.gctl.nmi_en;
    assign mode_w           = st.mode;
    assign region_w         = st.region;
    assign idx_vld_w        = st.idx_vld;
    assign idx_w            = st.idx;
    assign unused_addr_bits = ^acc_addr[ADDR_W-3:0];

    lockcfg_decode #(.NVIS(NVIS)) i_decode (
        .idx       (st.idx),
        .map_en    (st.gctl.map_en),
        .hit_mctl  (hit_mctl),
        .hit_pctl  (hit_pctl),
        .hit_gctl  (hit_gctl),
        .hit_rgn   (hit_rgn),
        .hit_id_lo (hit_id_lo),
        .hit_id_hi (hit_id_hi)
    );

    lockcfg_regs #(
        .IDX_PORT (IDX_PORT),
        .DAT_PORT (DAT_PORT),
        .ID_LO    (ID_LO),
        .ID_HI    (ID_HI),
        .NVIS     (NVIS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .in_mgmt   (in_mgmt),
        .hit_mctl  (hit_mctl),
        .hit_pctl  (hit_pctl),
        .hit_gctl  (hit_gctl),
        .hit_rgn   (hit_rgn),
        .hit_id_lo (hit_id_lo),
        .hit_id_hi (hit_id_hi),
        .io_rdata  (io_rdata),
        .state_q   (st)
    );

    lockcfg_ctl #(.IDX_PORT(IDX_PORT)) i_ctl (
        .mode         (st.mode),
        .pctl         (st.pctl),
        .gctl         (st.gctl),
        .in_mgmt      (in_mgmt),
        .mgmt_pin_n   (mgmt_pin_n),
        .mgmt_insn    (mgmt_insn),
        .pause_pin_n  (pause_pin_n),
        .halt_done    (halt_done),
        .addr_qtr     (acc_addr[ADDR_W-1 -: 2]),
        .io_rd        (io_rd),
        .io_wr        (io_wr),
        .io_addr      (io_addr),
        .mgmt_entry   (mgmt_entry),
        .pause_req    (pause_req),
        .nmi_in_mgmt  (nmi_in_mgmt),
        .nw_lock      (nw_lock),
        .strong_order (strong_order),
        .io_trap      (io_trap)
    );
endmodule

// File: rtl/lockcfg_chk.sv
module lockcfg_chk
    import lockcfg_pkg::*;
#(
    parameter logic [7:0] DAT_PORT = 8'h23
) (
    input logic                clk,
    input logic                rst_n,
    input logic                io_rd,
    input logic                io_wr,
    input logic [7:0]          io_addr,
    input logic [7:0]          io_rdata,
    input logic                in_mgmt,
    input logic                mgmt_pin_n,
    input logic                mgmt_insn,
    input logic                mgmt_entry,
    input logic [1:0]          addr_top,
    input logic                strong_order,
    input logic                lock_w,
    input logic                nmi_w,
    input logic [1:0]          mode_w,
    input logic [REGION_W-1:0] region_w,
    input logic                idx_vld_w,
    input logic [7:0]          idx_w
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == DAT_PORT && idx_vld_w && idx_w == IDX_MCTL)
        |-> (io_rdata[7:2] == 6'b0));

    p_src_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == 2'b00 || mode_w == 2'b10) |-> !mgmt_entry);

    p_src_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == 2'b01) |-> (mgmt_entry == !mgmt_pin_n));

    p_src_insn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == 2'b11) |-> (mgmt_entry == mgmt_insn));

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> lock_w);

    p_guard_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w && !in_mgmt) |=> ($stable(mode_w) && $stable(nmi_w) && $stable(region_w)));

    p_low_qtr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_top == 2'b00) |-> !strong_order);

    p_idx_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_addr == DAT_PORT) |=> !idx_vld_w);

    p_stale_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == DAT_PORT && !idx_vld_w) |-> (io_rdata == 8'hFF));
endmodule

bind lockcfg_bank lockcfg_chk #(.DAT_PORT(DAT_PORT)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_addr      (io_addr),
    .io_rdata     (io_rdata),
    .in_mgmt      (in_mgmt),
    .mgmt_pin_n   (mgmt_pin_n),
    .mgmt_insn    (mgmt_insn),
    .mgmt_entry   (mgmt_entry),
    .addr_top     (acc_addr[ADDR_W-1 -: 2]),
    .strong_order (strong_order),
    .lock_w       (lock_w),
    .nmi_w        (nmi_w),
    .mode_w       (mode_w),
    .region_w     (region_w),
    .idx_vld_w    (idx_vld_w),
    .idx_w        (idx_w)
);

// File: tb/test_lockcfg_bank.sv
module test_lockcfg_bank;
    localparam time        CLK_PERIOD = 10ns;
    localparam logic [7:0] P_IDX      = 8'h22;
    localparam logic [7:0] P_DAT      = 8'h23;
    localparam logic [7:0] ID_LO      = 8'h5A;
    localparam logic [7:0] ID_HI      = 8'hA6;
    localparam int         NVEC       = 38;

    // entry = {is_read, at_data_port, write_data, expected_read}
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {1'b0,1'b0,8'hC1,8'h00}, {1'b0,1'b1,8'h03,8'h00},
        {1'b0,1'b0,8'hC1,8'h00}, {1'b1,1'b1,8'h00,8'h03},
        {1'b0,1'b0,8'hC2,8'h00}, {1'b0,1'b1,8'hFF,8'h00},
        {1'b0,1'b0,8'hC2,8'h00}, {1'b1,1'b1,8'h00,8'h0F},
        {1'b0,1'b0,8'hC3,8'h00}, {1'b0,1'b1,8'hF6,8'h00},
        {1'b0,1'b0,8'hC3,8'h00}, {1'b1,1'b1,8'h00,8'h76},
        {1'b0,1'b0,8'hCD,8'h00}, {1'b0,1'b1,8'h11,8'h00},
        {1'b0,1'b0,8'hCE,8'h00}, {1'b0,1'b1,8'h22,8'h00},
        {1'b0,1'b0,8'hCF,8'h00}, {1'b0,1'b1,8'h33,8'h00},
        {1'b0,1'b0,8'hCD,8'h00}, {1'b1,1'b1,8'h00,8'h11},
        {1'b0,1'b0,8'hCE,8'h00}, {1'b1,1'b1,8'h00,8'h22},
        {1'b0,1'b0,8'hCF,8'h00}, {1'b1,1'b1,8'h00,8'h33},
        {1'b0,1'b0,8'hFE,8'h00}, {1'b1,1'b1,8'h00,ID_LO},
        {1'b0,1'b0,8'hFF,8'h00}, {1'b1,1'b1,8'h00,ID_HI},
        {1'b0,1'b0,8'hFE,8'h00}, {1'b0,1'b1,8'h00,8'h00},
        {1'b0,1'b0,8'hFE,8'h00}, {1'b1,1'b1,8'h00,ID_LO},
        {1'b0,1'b0,8'hC0,8'h00}, {1'b1,1'b1,8'h00,8'hFF},
        {1'b0,1'b0,8'hC1,8'h00}, {1'b1,1'b1,8'h00,8'h03},
        {1'b1,1'b1,8'h00,8'hFF}, {1'b1,1'b0,8'h00,8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_trap;
    logic        in_mgmt = 1'b0;
    logic        mgmt_pin_n = 1'b1;
    logic        mgmt_insn = 1'b0;
    logic        pause_pin_n = 1'b1;
    logic        halt_done = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        mgmt_entry;
    logic        pause_req;
    logic        nmi_in_mgmt;
    logic        nw_lock;
    logic        strong_order;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockcfg_bank #(
        .ADDR_W(32), .IDX_PORT(P_IDX), .DAT_PORT(P_DAT), .ID_LO(ID_LO), .ID_HI(ID_HI)
    ) i_lockcfg_bank (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_trap(io_trap), .in_mgmt(in_mgmt),
        .mgmt_pin_n(mgmt_pin_n), .mgmt_insn(mgmt_insn), .pause_pin_n(pause_pin_n),
        .halt_done(halt_done), .acc_addr(acc_addr), .mgmt_entry(mgmt_entry),
        .pause_req(pause_req), .nmi_in_mgmt(nmi_in_mgmt), .nw_lock(nw_lock),
        .strong_order(strong_order)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_addr = port; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] port, output logic [7:0] data);
        @(negedge clk);
        io_rd = 1'b1; io_addr = port;
        #1 data = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] data);
        io_write(P_IDX, idx);
        io_write(P_DAT, data);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] data);
        io_write(P_IDX, idx);
        io_read(P_DAT, data);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        do_reset();

        // R1: reset state
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ix;
            ix = (k < 3) ? (8'hC1 + 8'(k)) : (8'hCD + 8'(k - 3));
            reg_rd(ix, rv);
            check("R1 reg", {24'h0, rv}, 32'h0);
        end
        settle();
        check("R1 outputs", {27'h0, mgmt_entry, pause_req, nmi_in_mgmt, nw_lock, strong_order}, 32'h0);
        do_reset();
        io_read(P_DAT, rv);
        check("R1 index invalid", {24'h0, rv}, 32'hFF);

        // R2 R11 R12 R13: vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] port;
            port = VEC[v][16] ? P_DAT : P_IDX;
            if (VEC[v][17]) begin
                io_read(port, rv);
                check($sformatf("R2/R11/R12/R13 vector %0d", v), {24'h0, rv}, {24'h0, VEC[v][7:0]});
            end else begin
                io_write(port, VEC[v][15:8]);
            end
        end
        // R12: write to unimplemented index leaves neighbours unchanged
        reg_wr(8'hC4, 8'h55);
        reg_rd(8'hC1, rv);
        check("R12 no side effect", {24'h0, rv}, 32'h03);
        // R11: a data write with no fresh index is dropped
        io_write(P_DAT, 8'h00);
        reg_rd(8'hC1, rv);
        check("R11 stale write", {24'h0, rv}, 32'h03);

        // R3: entry source
        do_reset();
        mgmt_pin_n = 1'b0; mgmt_insn = 1'b1;
        settle(); check("R3 mode00", {31'h0, mgmt_entry}, 32'h0);
        reg_wr(8'hC1, 8'h02);
        settle(); check("R3 mode10", {31'h0, mgmt_entry}, 32'h0);
        reg_wr(8'hC1, 8'h01);
        mgmt_pin_n = 1'b0; mgmt_insn = 1'b0;
        settle(); check("R3 mode01 pin", {31'h0, mgmt_entry}, 32'h1);
        mgmt_pin_n = 1'b1; mgmt_insn = 1'b1;
        settle(); check("R3 mode01 insn ignored", {31'h0, mgmt_entry}, 32'h0);
        reg_wr(8'hC1, 8'h03);
        settle(); check("R3 mode11 insn", {31'h0, mgmt_entry}, 32'h1);
        mgmt_pin_n = 1'b0; mgmt_insn = 1'b0;
        settle(); check("R3 mode11 pin ignored", {31'h0, mgmt_entry}, 32'h0);
        mgmt_pin_n = 1'b1;

        // R7: ordering quarters
        reg_wr(8'hC3, 8'h70);
        acc_addr = 32'h3FFF_FFFF; settle(); check("R7 low", {31'h0, strong_order}, 32'h0);
        acc_addr = 32'h4000_0000; settle(); check("R7 q1", {31'h0, strong_order}, 32'h1);
        acc_addr = 32'hFFFF_FFFF; settle(); check("R7 q3", {31'h0, strong_order}, 32'h1);
        reg_wr(8'hC3, 8'h20);
        acc_addr = 32'h8000_0000; settle(); check("R7 q2 only", {31'h0, strong_order}, 32'h1);
        acc_addr = 32'hC000_0000; settle(); check("R7 q3 off", {31'h0, strong_order}, 32'h0);
        acc_addr = 32'h7FFF_FFFF; settle(); check("R7 q1 off", {31'h0, strong_order}, 32'h0);

        // R6: trap on index port and reach with map-enable
        @(negedge clk); io_wr = 1'b1; io_addr = P_IDX; io_wdata = 8'hC4;
        #1 check("R6 no trap", {31'h0, io_trap}, 32'h0);
        @(negedge clk); io_wr = 1'b0;
        reg_wr(8'hC3, 8'h08);
        @(negedge clk); io_rd = 1'b1; io_addr = P_IDX;
        #1 check("R6 trap read", {31'h0, io_trap}, 32'h1);
        @(negedge clk); io_rd = 1'b0;
        reg_rd(8'hC4, rv);
        check("R12 unimplemented with map", {24'h0, rv}, 32'hFF);
        reg_rd(8'hC3, rv);
        check("R6 map bit", {24'h0, rv}, 32'h08);

        // R8 R9 R10: pause, halt, nmi, nw lock
        do_reset();
        pause_pin_n = 1'b0;
        settle(); check("R8 gated off", {31'h0, pause_req}, 32'h0);
        reg_wr(8'hC2, 8'h01);
        settle(); check("R8 pin", {31'h0, pause_req}, 32'h1);
        in_mgmt = 1'b1;
        settle(); check("R8 in mgmt blocked", {31'h0, pause_req}, 32'h0);
        reg_wr(8'hC3, 8'h04);
        settle(); check("R8 in mgmt allowed", {31'h0, pause_req}, 32'h1);
        in_mgmt = 1'b0; pause_pin_n = 1'b1;
        reg_wr(8'hC2, 8'h02);
        halt_done = 1'b1;
        settle(); check("R9 halt", {31'h0, pause_req}, 32'h1);
        reg_wr(8'hC2, 8'h04);
        settle(); check("R9 halt off", {31'h0, pause_req}, 32'h0);
        check("R10 nw", {31'h0, nw_lock}, 32'h1);
        halt_done = 1'b0;
        reg_wr(8'hC3, 8'h02);
        settle(); check("R10 nmi", {31'h0, nmi_in_mgmt}, 32'h1);

        // R4 R5: lock
        do_reset();
        reg_wr(8'hC1, 8'h01);
        reg_wr(8'hCD, 8'hAA);
        reg_wr(8'hC3, 8'h03);
        reg_wr(8'hC1, 8'h03);
        reg_rd(8'hC1, rv); check("R5 mode held", {24'h0, rv}, 32'h01);
        reg_wr(8'hC3, 8'h00);
        reg_rd(8'hC3, rv); check("R4 R5 lock and nmi held", {24'h0, rv}, 32'h03);
        reg_wr(8'hCD, 8'h55);
        reg_rd(8'hCD, rv); check("R5 region held", {24'h0, rv}, 32'hAA);
        reg_wr(8'hC2, 8'h04);
        reg_rd(8'hC2, rv); check("R5 other reg writable", {24'h0, rv}, 32'h04);
        reg_wr(8'hC3, 8'h41);
        reg_rd(8'hC3, rv); check("R5 other bits writable", {24'h0, rv}, 32'h43);
        in_mgmt = 1'b1;
        reg_wr(8'hC1, 8'h03);
        reg_rd(8'hC1, rv); check("R5 mode in mgmt", {24'h0, rv}, 32'h03);
        reg_wr(8'hC3, 8'h00);
        reg_rd(8'hC3, rv); check("R4 lock stays in mgmt", {24'h0, rv}, 32'h01);
        reg_wr(8'hCD, 8'h55);
        reg_rd(8'hCD, rv); check("R5 region in mgmt", {24'h0, rv}, 32'h55);
        in_mgmt = 1'b0;
        do_reset();
        reg_rd(8'hC3, rv); check("R4 reset clears lock", {24'h0, rv}, 32'h00);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule